// File: doc/BRIEF.md
# Local interrupt controller countdown timer

This block is the countdown timer of a per-processor interrupt controller. Software programs it through a word-indexed register window. Four registers are mapped in that window. The first is a timer entry, which holds the 8-bit vector, a mask bit and a periodic/one-shot select. The second is an initial-count register. The third is a read-only current-count register. The fourth is a 4-bit divide-configuration field that selects a power-of-two prescale from 1 to 128. When the count expires and the entry is unmasked, the block emits a one-cycle request that carries the programmed vector.

A free-running 7-bit prescaler produces one timer tick each time its low `shift` bits return to zero. The count engine is a three-state machine. In ST_IDLE, which follows reset, the count sits at 0 and nothing fires. A write to the initial count moves the engine from any state to ST_COUNT and loads the written value at once. In ST_COUNT each tick lowers a non-zero count by one. A tick that finds the count at 0 is an expiry. In periodic mode an expiry reloads the initial count and the engine stays in ST_COUNT. In one-shot mode an expiry moves the engine to ST_EXPIRED, where the count holds at 0 until the next initial-count write. One case never expires: periodic mode with an initial count of 0 stays in ST_COUNT at 0.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the timer entry reads 0x00010000 (masked), the initial count, current count and divide configuration read 0, and no request is raised.
- R2: The register index is address bits [11:4]. The timer entry is at 0x32, the initial count at 0x38, the current count at 0x39 and the divide configuration at 0x3E. Any other index reads 0, and writes to it change none of the four registers.
- R3: A divide-configuration write stores only the bits under mask 0xB, and a read returns that stored value.
- R4: With v = {bit3, bit1, bit0} of the divide configuration, the prescale shift is (v+1) mod 8 and one tick occurs every 2^shift cycles. Code 0xB divides by 1, and code 0xA divides by 128.
- R5: A write of N to the initial count makes the current count read N in the cycle after the write edge, whatever count was in progress.
- R6: In one-shot mode (entry bit 17 = 0) the current count falls by one per tick to 0 and stays there. Exactly one request is raised, N+1 ticks after the write.
- R7: In periodic mode (entry bit 17 = 1) with N > 0, the count reloads to N after reaching 0, and requests repeat every (N+1)·2^shift cycles.
- R8: In periodic mode with an initial count of 0, no request is ever raised.
- R9: When entry bit 16 is set, expiries raise no request and counting continues. Clearing the bit lets later expiries raise requests again.
- R10: A request is a single-cycle pulse on `irq_pulse`, with `irq_vector` equal to entry bits [7:0].
- R11: Writes to the current-count index are ignored.
- R12: After a one-shot expiry, no further request is raised, even if the entry is rewritten to periodic, until the initial count is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register index (address bits [11:4]) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request on unmasked expiry |
| irq_vector | output | 8 | Vector carried with `irq_pulse` |

## Verification
The assertions take for granted that `reg_we` is never X while the block is out of reset. They also assume that only the initial-count index reloads the engine. With that, any change of the count other than a single-step decrement must be a reload to the stored initial value. The single-pulse property relies on every expiry being separated from the next by at least two ticks. That holds for one-shot mode, because it fires once, and for periodic mode with N ≥ 1, because the period is at least two cycles. The bench keeps to these assumptions: it changes inputs only on falling edges, so every write is a clean one-cycle strobe, and it never writes the initial count in the same cycle it expects an expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [7:0]  IDX_ENTRY = 8'h32;
    localparam logic [7:0]  IDX_INIT  = 8'h38;
    localparam logic [7:0]  IDX_CUR   = 8'h39;
    localparam logic [7:0]  IDX_DIV   = 8'h3E;
    localparam logic [31:0] DIV_KEEP  = 32'h0000_000B;
    localparam logic [31:0] ENTRY_RST = 32'h0001_0000;
    localparam int          BIT_PERIODIC = 17;
    localparam int          BIT_MASK     = 16;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } tmr_state_e;

    // prescale shift from the scrambled divide code
    function automatic logic [2:0] div_shift(input logic [3:0] code);
        logic [2:0] v;
        v = {code[3], code[1:0]};
        return v + 3'd1;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRESC_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] shift,
    output logic       tick
);
    logic [PRESC_W-1:0] cnt_q;
    logic [PRESC_W-1:0] roll_mask;

    for (genvar i = 0; i < PRESC_W; i++) begin : g_mask
        assign roll_mask[i] = (int'(shift) > i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign tick = ((cnt_q & roll_mask) == '0);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_idx,
    input  logic [31:0]      reg_wdata,
    input  logic [CNT_W-1:0] cur_count,
    output logic [31:0]      reg_rdata,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] init_val,
    output logic             periodic,
    output logic             masked,
    output logic [7:0]       vector,
    output logic [2:0]       shift
);
    logic [31:0]      entry_q;
    logic [31:0]      div_q;
    logic [CNT_W-1:0] init_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= ENTRY_RST;
            div_q   <= '0;
            init_q  <= '0;
        end else if (reg_we) begin
            unique case (reg_idx)
                IDX_ENTRY: entry_q <= reg_wdata;
                IDX_INIT:  init_q  <= reg_wdata[CNT_W-1:0];
                IDX_DIV:   div_q   <= reg_wdata & DIV_KEEP;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_idx)
            IDX_ENTRY: reg_rdata = entry_q;
            IDX_INIT:  reg_rdata = 32'(init_q);
            IDX_CUR:   reg_rdata = 32'(cur_count);
            IDX_DIV:   reg_rdata = div_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign load     = reg_we && (reg_idx == IDX_INIT);
    assign load_val = reg_wdata[CNT_W-1:0];
    assign init_val = init_q;
    assign periodic = entry_q[BIT_PERIODIC];
    assign masked   = entry_q[BIT_MASK];
    assign vector   = entry_q[7:0];
    assign shift    = div_shift(div_q[3:0]);
endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    input  logic [7:0]       vector,
    output logic [CNT_W-1:0] cur_count,
    output logic             irq_pulse,
    output logic [7:0]       irq_vector
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;
    logic             pulse_q;
    logic [7:0]       vec_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (load) begin
            state_d = ST_COUNT;
            cnt_d   = load_val;
        end else begin
            unique case (state_q)
                ST_IDLE:    ;
                ST_COUNT: begin
                    if (tick) begin
                        if (cnt_q != '0) begin
                            cnt_d = cnt_q - 1'b1;
                        end else if (periodic) begin
                            if (init_val != '0) begin
                                cnt_d = init_val;
                                fire  = 1'b1;
                            end
                        end else begin
                            fire    = 1'b1;
                            state_d = ST_EXPIRED;
                        end
                    end
                end
                ST_EXPIRED: ;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            vec_q   <= '0;
        end else begin
            pulse_q <= fire && !masked;
            vec_q   <= (fire && !masked) ? vector : 8'h00;
        end
    end

    assign cur_count  = cnt_q;
    assign irq_pulse  = pulse_q;
    assign irq_vector = vec_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R10
    AST_EXPIRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED && !load) |=> !pulse_q); // R12
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && cnt_q != $past(cnt_q)) |->
            (cnt_q == $past(cnt_q) - 1'b1 || cnt_q == $past(init_val))); // R6
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
    parameter int CNT_W   = 32,
    parameter int PRESC_W = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:4] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_pulse,
    output logic [7:0]  irq_vector
);
    logic             load, periodic, masked, tick;
    logic [CNT_W-1:0] load_val, init_val, cur_count;
    logic [7:0]       vector;
    logic [2:0]       shift;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_addr),
        .reg_wdata(reg_wdata), .cur_count(cur_count), .reg_rdata(reg_rdata),
        .load(load), .load_val(load_val), .init_val(init_val),
        .periodic(periodic), .masked(masked), .vector(vector), .shift(shift)
    );

    tmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .shift(shift), .tick(tick)
    );

    tmr_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .init_val(init_val), .tick(tick), .periodic(periodic),
        .masked(masked), .vector(vector), .cur_count(cur_count),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(masked)); // R9
    AST_CUR_LE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        cur_count <= init_val); // R5
    AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_vector == $past(vector)); // R10
endmodule

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:4] reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [31:0] v);
        reg_addr = idx;
        #1;
        v = reg_rdata;
    endtask

    // wait for a pulse at falling edges; returns cycles waited
    task automatic wait_pulse(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_pulse && n < limit);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int n, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h32, v); chk(v == 32'h0001_0000, "R1 entry", v, 32'h0001_0000);
        rd(8'h38, v); chk(v == 0, "R1 init", v, 0);
        rd(8'h39, v); chk(v == 0, "R1 cur", v, 0);
        rd(8'h3E, v); chk(v == 0, "R1 div", v, 0);
        chk(irq_pulse == 1'b0, "R1 pulse", irq_pulse, 0);

        // R2 unmapped index
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h20, v); chk(v == 0, "R2 unmapped read", v, 0);
        rd(8'h38, v); chk(v == 0, "R2 init untouched", v, 0);
        rd(8'h32, v); chk(v == 32'h0001_0000, "R2 entry untouched", v, 32'h0001_0000);

        // R11 current count is read-only
        wr(8'h39, 32'h55);
        rd(8'h39, v); chk(v == 0, "R11 cur write ignored", v, 0);
        rd(8'h38, v); chk(v == 0, "R11 init untouched", v, 0);

        // R3 divide mask sweep
        for (int c = 0; c < 16; c++) begin
            wr(8'h3E, 32'hFFFF_FFF0 | c);
            rd(8'h3E, v);
            chk(v == (c & 32'hB), "R3 div mask", v, c & 32'hB);
        end

        // R5 R6 R10 one-shot sweep at divide-by-1
        for (int nn = 0; nn <= 6; nn++) begin
            wr(8'h32, 32'h40 + nn);
            wr(8'h3E, 32'hB);
            wr(8'h38, nn);
            for (int k = 0; k <= nn + 8; k++) begin
                if (k > 0) @(negedge clk);
                rd(8'h39, v);
                if (k == 0) chk(v == nn, "R5 load visible", v, nn);
                else chk(v == ((k <= nn) ? nn - k : 0), "R6 one-shot count", v, (k <= nn) ? nn - k : 0);
                chk(irq_pulse == (k == nn + 1), "R6 one-shot pulse timing", irq_pulse, k == nn + 1);
                if (irq_pulse) chk(irq_vector == 8'(32'h40 + nn), "R10 vector", irq_vector, 32'h40 + nn);
            end
        end

        // R12 expired one-shot stays silent after entry rewrite
        wr(8'h32, 32'h0002_0077);
        cnt = 0;
        for (int k = 0; k < 50; k++) begin @(negedge clk); if (irq_pulse) cnt++; end
        chk(cnt == 0, "R12 no re-fire", cnt, 0);
        rd(8'h39, v); chk(v == 0, "R12 count held", v, 0);

        // R5 restart mid-count
        wr(8'h32, 32'h0001_0000);
        wr(8'h38, 20);
        repeat (5) @(negedge clk);
        wr(8'h38, 9);
        rd(8'h39, v); chk(v == 9, "R5 restart", v, 9);

        // R4 R7 periodic interval over all divide codes
        for (int c = 0; c < 16; c++) begin
            int sh, exp;
            if ((c & 4) != 0) continue;
            sh  = ((((c >> 1) & 4) | (c & 3)) + 1) & 7;
            exp = 4 << sh;
            wr(8'h32, 32'h0002_0090);
            wr(8'h3E, c);
            wr(8'h38, 3);
            wait_pulse(2000, n);
            wait_pulse(2000, n);
            chk(irq_pulse == 1'b1, "R7 pulse seen", irq_pulse, 1);
            wait_pulse(2000, n);
            chk(n == exp, "R4 periodic interval per divide", n, exp);
            chk(irq_vector == 8'h90, "R10 periodic vector", irq_vector, 8'h90);
        end

        // R7 other counts at divide-by-1, reload check
        for (int nn = 1; nn <= 5; nn += 2) begin
            wr(8'h3E, 32'hB);
            wr(8'h38, nn);
            wait_pulse(200, n);
            rd(8'h39, v); chk(v == nn, "R7 reload", v, nn);
            wait_pulse(200, n);
            chk(n == nn + 1, "R7 interval", n, nn + 1);
        end

        // R8 periodic with zero count
        wr(8'h38, 0);
        cnt = 0;
        for (int k = 0; k < 300; k++) begin @(negedge clk); if (irq_pulse) cnt++; end
        chk(cnt == 0, "R8 no pulse", cnt, 0);
        rd(8'h39, v); chk(v == 0, "R8 count zero", v, 0);

        // R9 mask
        wr(8'h32, 32'h0003_0021);
        wr(8'h38, 3);
        cnt = 0;
        for (int k = 0; k < 100; k++) begin @(negedge clk); if (irq_pulse) cnt++; end
        chk(cnt == 0, "R9 masked silent", cnt, 0);
        rd(8'h39, v); @(negedge clk); rd(8'h39, v2);
        chk(v != v2, "R9 counting continues", v2, v);
        wr(8'h32, 32'h0002_0021);
        wait_pulse(20, n);
        chk(irq_pulse == 1'b1, "R9 unmask resumes", irq_pulse, 1);
        chk(irq_vector == 8'h21, "R10 vector after unmask", irq_vector, 8'h21);
        @(negedge clk);
        chk(irq_pulse == 1'b0, "R10 single cycle", irq_pulse, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule